// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a four-wire serial slave that lets a host controller program and read back a small bank of byte-wide configuration registers. A transaction is framed by an active-low select. While the select is low, the host clocks a 24-bit word in, most significant bit first. The word holds, from the top down:

- a 7-bit device identifier,
- a read/write flag,
- an 8-bit register index,
- an 8-bit data byte.

For a write, the data byte is stored when the select returns high. The word must carry the device identifier 0x04 and exactly 24 serial clocks. For a read, the selected register is shifted back on the serial output during the last eight clocks of the frame. An enable output tells the pad when to drive; otherwise the pad stays in high impedance.

The serial pins can run with no phase relation to the system clock. All four pins pass through synchronisers and are oversampled in the system clock domain. The serial clock must therefore be slower than about one eighth of the system clock. The stored configuration is presented as a flat vector in the system clock domain, together with a one-cycle strobe for every accepted write. One bit of register 1 is a read-only mirror of an external lock indicator.

Top module: `spi_cfg_port`

## Requirements
- R1: A frame is the 24 bits sampled on serial clock rising edges while sel_n is low, MSB first. Bits 23:17 are the device identifier, bit 16 is the read/write flag (0 = write, 1 = read), bits 15:8 are the register index and bits 7:0 are the data. An accepted write stores the data byte into byte `index` of cfg_flat (bits index*8+7 down to index*8) within a few system clocks after sel_n rises.
- R2: A frame whose identifier is not 0x04 has no effect. A write to such a frame changes no register, and a read to such a frame never asserts sdo_oe.
- R3: A frame that carries fewer or more than 24 rising serial clock edges while sel_n is low changes no register and produces no strobe.
- R4: In a read frame with a matching identifier, the register byte is driven on sdo MSB first. Each bit is launched after a falling serial clock edge, beginning with the falling edge that follows the 16th rising edge, so the host samples it on rising edges 17 to 24. sdo_oe is high only from that point until sel_n is high again. A read changes no register.
- R5: Indices 5 to 13, and every index above 16, are reserved. Writes to them are discarded and reads from them return 0x00. Indices 0 to 4 and 14 to 16 are writable.
- R6: While rst_n is low, all of cfg_flat is zero and sdo_oe and wr_strobe are low.
- R7: Bit 2 of register 1 is read-only. A read returns the synchronised pll_lock level there (1 = locked). Host writes to that bit are ignored, and its cfg_flat bit stays 0.
- R8: wr_strobe is high for exactly one system clock for each accepted write to a writable index. It stays low otherwise, and cfg_flat changes only in the cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Frame select from host, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| pll_lock | input | 1 | Lock indicator mirrored into register 1 bit 2 |
| sdo | output | 1 | Serial read data to host |
| sdo_oe | output | 1 | Pad drive enable for sdo; pad is high impedance when low |
| cfg_flat | output | 136 | All registers, byte i at bits i*8+7:i*8 |
| wr_strobe | output | 1 | One-cycle pulse per accepted write |

## Verification
Writes are tried at:

- the lowest writable index,
- the highest writable index,
- both edges of the reserved hole,
- an index beyond the map.

This separates a correct index decode from an off-by-one at either end of the hole. Frames with 23 and 25 clocks and a wrong identifier are mixed among valid frames, which shows that a rejected frame leaves no residue. Read frames return alternating and walking patterns, which expose bit-order and launch-edge errors on sdo. Toggling pll_lock between reads of register 1, after all-ones writes to it, shows that the lock bit comes from the input and not from storage.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
   localparam int FRAME_W = 24;
   localparam int BYTE_W  = 8;
   localparam int ADDR_W  = 8;
   localparam int ID_W    = 7;
   localparam int HDR_W   = FRAME_W - BYTE_W;

   typedef struct packed {
      logic [ID_W-1:0]   dev_id;
      logic              is_rd;
      logic [ADDR_W-1:0] index;
      logic [BYTE_W-1:0] payload;
   } frame_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
   import spi_cfg_pkg::*;
#(
   parameter logic [ID_W-1:0] DEV_ID = 7'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sel_s,
   input  logic              sdi_s,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic [ADDR_W-1:0] rd_index,
   output logic              wr_fire,
   output logic [ADDR_W-1:0] wr_index,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);

   logic               sclk_q, sel_q;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] sh;
   logic [BYTE_W-1:0]  rd_sh;
   logic               sdo_q, oe_q;
   logic               rise, fall, sel_rise, hdr_rd_ok, in_data;
   frame_t             fr;

   assign fr        = frame_t'(sh);
   assign rise      = sclk_s & ~sclk_q;
   assign fall      = ~sclk_s & sclk_q;
   assign sel_rise  = sel_s & ~sel_q;
   // at the 16th edge the header sits in the low 16 bits of the shifter
   assign rd_index  = sh[ADDR_W-1:0];
   assign hdr_rd_ok = (sh[HDR_W-1 -: ID_W] == DEV_ID) && sh[ADDR_W];
   assign in_data   = (cnt >= CNT_HDR) && (cnt < CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
         sel_q  <= 1'b1;
         cnt    <= '0;
         sh     <= '0;
         rd_sh  <= '0;
         sdo_q  <= 1'b0;
         oe_q   <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         sel_q  <= sel_s;
         if (sel_s) begin
            cnt  <= '0;
            oe_q <= 1'b0;
         end else begin
            if (rise) begin
               sh <= {sh[FRAME_W-2:0], sdi_s};
               if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
            end
            if (fall && in_data) begin
               if (cnt == CNT_HDR) begin
                  if (hdr_rd_ok) begin
                     oe_q  <= 1'b1;
                     sdo_q <= rd_byte[BYTE_W-1];
                     rd_sh <= {rd_byte[BYTE_W-2:0], 1'b0};
                  end
               end else begin
                  sdo_q <= rd_sh[BYTE_W-1];
                  rd_sh <= {rd_sh[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign wr_fire  = sel_rise && (cnt == CNT_FULL) && (fr.dev_id == DEV_ID) && !fr.is_rd;
   assign wr_index = fr.index;
   assign wr_byte  = fr.payload;
   assign sdo      = sdo_q & oe_q;
   assign sdo_oe   = oe_q;
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
   import spi_cfg_pkg::*;
#(
   parameter int N_REGS   = 17,
   parameter int RSV_LO   = 5,
   parameter int RSV_HI   = 13,
   parameter int LOCK_REG = 1,
   parameter int LOCK_BIT = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [BYTE_W-1:0]        wdata,
   input  logic [ADDR_W-1:0]        raddr,
   input  logic                     lock_s,
   output logic [BYTE_W-1:0]        rdata,
   output logic [N_REGS*BYTE_W-1:0] cfg_flat,
   output logic                     wr_strobe
);
   localparam logic [BYTE_W-1:0] RO_MASK = BYTE_W'(1) << LOCK_BIT;

   logic hit_ok;

   assign hit_ok = we && (waddr < ADDR_W'(N_REGS)) &&
                   !((waddr >= ADDR_W'(RSV_LO)) && (waddr <= ADDR_W'(RSV_HI)));

   for (genvar g = 0; g < N_REGS; g++) begin : g_reg
      if (g >= RSV_LO && g <= RSV_HI) begin : g_rsv
         assign cfg_flat[g*BYTE_W +: BYTE_W] = '0;
      end else begin : g_live
         localparam logic [BYTE_W-1:0] KEEP = (g == LOCK_REG) ? ~RO_MASK : '1;
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  q <= '0;
            else if (hit_ok && waddr == ADDR_W'(g))      q <= wdata & KEEP;
         end
         assign cfg_flat[g*BYTE_W +: BYTE_W] = q;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_REGS; i++) begin
         if (raddr == ADDR_W'(i)) begin
            rdata = cfg_flat[i*BYTE_W +: BYTE_W];
            if (i == LOCK_REG) rdata[LOCK_BIT] = lock_s;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_strobe <= 1'b0;
      else        wr_strobe <= hit_ok;
   end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
   import spi_cfg_pkg::*;
#(
   parameter int              N_REGS      = 17,
   parameter int              RSV_LO      = 5,
   parameter int              RSV_HI      = 13,
   parameter int              LOCK_REG    = 1,
   parameter int              LOCK_BIT    = 2,
   parameter int              SYNC_STAGES = 2,
   parameter logic [ID_W-1:0] DEV_ID      = 7'h04
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_n,
   input  logic                     sclk,
   input  logic                     sdi,
   input  logic                     pll_lock,
   output logic                     sdo,
   output logic                     sdo_oe,
   output logic [N_REGS*BYTE_W-1:0] cfg_flat,
   output logic                     wr_strobe
);
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (N_REGS < 1 || N_REGS > 255) begin : g_chk_nregs
      $error("N_REGS out of range");
   end
   if (RSV_LO > RSV_HI || RSV_HI >= N_REGS) begin : g_chk_rsv
      $error("reserved window outside register map");
   end
   if (LOCK_REG >= N_REGS || LOCK_BIT >= BYTE_W) begin : g_chk_lock
      $error("lock bit position outside register map");
   end

   logic [3:0]        pins_s;
   logic              sel_s, sclk_s, sdi_s, lock_s;
   logic [ADDR_W-1:0] rd_index, wr_index;
   logic [BYTE_W-1:0] rd_byte, wr_byte;
   logic              wr_fire;

   spi_cfg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pll_lock, sdi, sclk, sel_n}),
      .q     (pins_s)
   );
   assign {lock_s, sdi_s, sclk_s, sel_s} = pins_s;

   spi_cfg_frame #(.DEV_ID(DEV_ID)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (sclk_s),
      .sel_s    (sel_s),
      .sdi_s    (sdi_s),
      .rd_byte  (rd_byte),
      .rd_index (rd_index),
      .wr_fire  (wr_fire),
      .wr_index (wr_index),
      .wr_byte  (wr_byte),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe)
   );

   spi_cfg_regs #(
      .N_REGS(N_REGS), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI),
      .LOCK_REG(LOCK_REG), .LOCK_BIT(LOCK_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (wr_fire),
      .waddr     (wr_index),
      .wdata     (wr_byte),
      .raddr     (rd_index),
      .lock_s    (lock_s),
      .rdata     (rd_byte),
      .cfg_flat  (cfg_flat),
      .wr_strobe (wr_strobe)
   );
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
   parameter int CFG_W = 136
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_s,
   input logic             sdo_oe,
   input logic             wr_strobe,
   input logic [CFG_W-1:0] cfg_flat
);
   // R8: a strobe never lasts longer than one cycle
   p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe);

   // R8: a strobe only follows a synchronised select release
   p_strobe_after_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> $past(sel_s));

   // R1: configuration moves only together with the strobe
   p_cfg_moves_with_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_flat) |-> wr_strobe);

   // R4: output drive is released once the select has been high
   p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s && $past(sel_s)) |-> !sdo_oe);

   // R6: reset state
   p_reset_state_r6: assert property (@(posedge clk)
      !rst_n |-> (cfg_flat == '0 && !sdo_oe && !wr_strobe));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.CFG_W(N_REGS*spi_cfg_pkg::BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_s     (sel_s),
   .sdo_oe    (sdo_oe),
   .wr_strobe (wr_strobe),
   .cfg_flat  (cfg_flat)
);

// File: tb/spi_cfg_port_test.sv
`timescale 1ns/1ps
module spi_cfg_port_test;
   localparam int NR   = 17;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n, sel_n, sclk, sdi, pll_lock;
   logic sdo, sdo_oe, wr_strobe;
   logic [NR*8-1:0] cfg_flat;

   logic [NR*8-1:0] exp_cfg;
   logic            exp_strobe;
   int              checks = 0;
   int              errors = 0;
   bit              done = 0;

   always #5 clk = ~clk;

   spi_cfg_port uut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
      .pll_lock(pll_lock), .sdo(sdo), .sdo_oe(sdo_oe),
      .cfg_flat(cfg_flat), .wr_strobe(wr_strobe)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // per-clock comparison against the reference model (R1, R8)
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         checks++;
         if (cfg_flat !== exp_cfg || wr_strobe !== exp_strobe) begin
            errors++;
            $display("FAIL R1/R8 per-clock cfg=%0h strobe=%0b expected cfg=%0h strobe=%0b",
                     cfg_flat, wr_strobe, exp_cfg, exp_strobe);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      finish_run();
   end

   function automatic bit writable(input int a);
      return a < NR && !(a >= 5 && a <= 13);
   endfunction

   function automatic logic [7:0] model_read(input int a);
      logic [7:0] v;
      if (!writable(a)) return 8'h00;
      v = exp_cfg[a*8 +: 8];
      if (a == 1) v[2] = pll_lock;
      return v;
   endfunction

   function automatic logic [23:0] word(input logic [6:0] id, input bit rd, input logic [7:0] a, input logic [7:0] d);
      return {id, rd, a, d};
   endfunction

   task automatic xfer(input logic [23:0] w, input int nclk,
                       output logic [7:0] rd, output bit oe_all, output bit oe_any);
      bit commit;
      rd = 8'h00; oe_all = 1; oe_any = 0;
      @(negedge clk); sel_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nclk; i++) begin
         sclk = 1'b0;
         sdi  = (i < 24) ? w[23-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (sdo_oe) oe_any = 1;
         if (i >= 16 && i < 24) begin
            rd[23-i] = sdo;
            if (!sdo_oe) oe_all = 0;
         end
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      sel_n = 1'b1;
      commit = (nclk == 24) && (w[23:17] == 7'h04) && !w[16] && writable(int'(w[15:8]));
      repeat (3) @(posedge clk);
      if (commit) begin
         exp_cfg[int'(w[15:8])*8 +: 8] = (w[15:8] == 8'd1) ? (w[7:0] & 8'hFB) : w[7:0];
         exp_strobe = 1'b1;
      end
      @(posedge clk);
      exp_strobe = 1'b0;
      repeat (HALF) @(negedge clk);
      check(sdo_oe === 1'b0, "R4 oe released after frame", {31'd0, sdo_oe}, 32'd0);
   endtask

   task automatic do_read(input int a, input string req);
      logic [7:0] r; bit all, any; logic [7:0] e;
      e = model_read(a);
      xfer(word(7'h04, 1, 8'(a), 8'h5A), 24, r, all, any);
      check(r === e, req, {24'd0, r}, {24'd0, e});
      check(all, "R4 oe high during read data bits", {31'd0, all}, 32'd1);
   endtask

   task automatic do_write(input logic [6:0] id, input int a, input logic [7:0] d, input int n, input string req);
      logic [7:0] r; bit all, any;
      xfer(word(id, 0, 8'(a), d), n, r, all, any);
      check(!any, req, {31'd0, any}, 32'd0);
   endtask

   initial begin
      logic [7:0] r; bit all, any;
      rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b1; sdi = 1'b0; pll_lock = 1'b0;
      exp_cfg = '0; exp_strobe = 1'b0;
      repeat (4) @(negedge clk);
      // R6: reset state
      check(cfg_flat === '0, "R6 cfg zero in reset", cfg_flat[31:0], 32'd0);
      check(sdo_oe === 1'b0 && wr_strobe === 1'b0, "R6 oe/strobe low in reset",
            {30'd0, sdo_oe, wr_strobe}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      do_read(0, "R6 register 0 reads zero after reset");

      // R1: writes at both ends of the writable map
      do_write(7'h04, 0, 8'hA5, 24, "R1 no drive during write to 0");
      do_write(7'h04, 16, 8'h3C, 24, "R1 no drive during write to 16");
      do_write(7'h04, 4, 8'h81, 24, "R1 no drive during write to 4");
      do_write(7'h04, 14, 8'h7E, 24, "R1 no drive during write to 14");
      do_read(0, "R4 read back reg 0 alternating pattern");
      do_read(16, "R4 read back reg 16");
      do_read(4, "R4 read back reg 4 walking ends");
      do_read(14, "R4 read back reg 14");

      // R2: wrong identifier
      do_write(7'h05, 0, 8'h11, 24, "R2 no drive for wrong id write");
      xfer(word(7'h02, 1, 8'd0, 8'h00), 24, r, all, any);
      check(!any, "R2 wrong id read must not drive", {31'd0, any}, 32'd0);
      do_read(0, "R2 reg 0 unchanged by wrong id write");

      // R3: wrong clock counts
      do_write(7'h04, 2, 8'h99, 23, "R3 short frame");
      do_write(7'h04, 2, 8'h99, 25, "R3 long frame");
      do_read(2, "R3 reg 2 unchanged after bad-length frames");
      do_write(7'h04, 2, 8'h99, 24, "R3 exact frame");
      do_read(2, "R3 reg 2 written by exact frame");

      // R5: reserved holes and beyond the map
      do_write(7'h04, 5, 8'hFF, 24, "R5 write reserved 5");
      do_write(7'h04, 13, 8'hFF, 24, "R5 write reserved 13");
      do_write(7'h04, 200, 8'hFF, 24, "R5 write index 200");
      do_read(5, "R5 read reserved 5 gives zero");
      do_read(13, "R5 read reserved 13 gives zero");
      do_read(17, "R5 read index 17 gives zero");

      // R7: read-only lock bit
      do_write(7'h04, 1, 8'hFF, 24, "R7 write reg 1");
      check(cfg_flat[8+2] === 1'b0, "R7 lock bit not stored", {31'd0, cfg_flat[10]}, 32'd0);
      pll_lock = 1'b0; repeat (8) @(negedge clk);
      do_read(1, "R7 reg 1 with lock low");
      pll_lock = 1'b1; repeat (8) @(negedge clk);
      do_read(1, "R7 reg 1 with lock high");
      do_write(7'h04, 1, 8'h00, 24, "R7 clear reg 1");
      do_read(1, "R7 lock bit visible with reg 1 cleared");

      // R4: reads leave registers untouched (per-clock model enforces)
      do_read(16, "R4 second read of reg 16");
      do_write(7'h04, 3, 8'h01, 24, "R1 single low bit");
      do_read(3, "R4 walking one at LSB");

      repeat (10) @(negedge clk);
      done = 1;
      finish_run();
   end
endmodule